// File: doc/BRIEF.md
# Presettable BCD Up/Down Counter

This block is one decimal digit of counting. It holds a value from 0 to 9 and moves it one place up or down on each rising clock edge when the count enable is asserted. A direction input chooses between incrementing and decrementing. The counter wraps from 9 to 0 going up and from 0 to 9 going down. An active-low load input forces the digit to the value on four preset inputs. The load is level-sensitive and does not wait for a clock edge, and while it is held low the output tracks the preset inputs.

Two outputs support chaining digits. The terminal flag is active high. It marks the cycle in which the next enabled edge will wrap the digit. The ripple output is active low. It pulses low during the low half of the clock when the terminal flag is set and counting is enabled, and it can clock the next digit in a chain.

A loaded or power-up value outside 0 to 9 does not lock the counter. It returns to the decimal sequence within one or two enabled edges.

Top module: `bcd_updown_counter`

## Requirements
- R1: While `load_n` is low, `count` equals `preset` at once, with no clock edge needed, and it follows any change of `preset`.
- R2: With `load_n` high and `ce_n` high, a rising clock edge leaves `count` unchanged.
- R3: With `load_n` high, `ce_n` low and `dn` = 0, a rising edge moves `count` from v to v+1 for v in 0..8, and from 9 to 0.
- R4: With `load_n` high, `ce_n` low and `dn` = 1, a rising edge moves `count` from v to v-1 for v in 1..9, and from 0 to 9.
- R5: `tc` is 1 exactly when (`dn` = 0 and `count` = 9) or (`dn` = 1 and `count` = 0). Otherwise, including for every value from 10 to 15, it is 0.
- R6: `rc_n` is 0 only while `clk` is low, `tc` is 1 and `ce_n` is 0. At all other times it is 1.
- R7: When counting up from a value above 9, the next states are 10→11, 11→6, 12→13, 13→4, 14→15 and 15→2, so the counter is back in 0..9 within two enabled edges.
- R8: When counting down from any value from 10 to 15, the next enabled edge sets `count` to 9.
- R9: A rising edge while `load_n` is low, with `ce_n` low, does not count. `count` keeps the preset value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Count clock, active on the rising edge |
| load_n | input | 1 | Asynchronous level load, active low |
| ce_n | input | 1 | Count enable, active low |
| dn | input | 1 | Direction: 0 counts up, 1 counts down |
| preset | input | 4 | Value applied while load is active |
| count | output | 4 | Current digit value |
| tc | output | 1 | Terminal flag, high in the cycle before a wrap |
| rc_n | output | 1 | Ripple clock, active low during the low clock phase |

## Verification
The bound checker checks these on every clock edge: the digit follows the preset while load is low, the digit holds when counting is disabled, the up step, the down wrap, illegal down recovery, the terminal decode, and the ripple output level in both clock phases. Some behaviour only the bench scenarios can show. One is that the digit follows the preset between clock edges during a load. Another is that every illegal start value follows the full two-step up path. A third is that the ripple output falls in the low half of one particular cycle. The bench's scoreboard compares each of these with an independent model.

// File: rtl/bcd_cnt_pkg.sv
package bcd_cnt_pkg;

    // Width of one decimal digit and its largest legal value
    localparam int DIGIT_W   = 4;
    localparam int DIGIT_MAX = 9;
    localparam int CODE_MAX  = (1 << DIGIT_W) - 1;

    typedef logic [DIGIT_W-1:0] digit_t;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    typedef struct packed {
        digit_t value;
    } cnt_state_t;

    localparam digit_t TOP_CODE = digit_t'(DIGIT_MAX);
    localparam digit_t LOW_CODE = '0;

endpackage

// File: rtl/bcd_step_map.sv
module bcd_step_map
    import bcd_cnt_pkg::*;
(
    input  digit_t cur,
    input  logic   dn,
    output digit_t nxt
);

    digit_t up_val;
    digit_t down_val;
    logic   legal;

    assign legal = (cur <= TOP_CODE);

    // Upward map: legal codes step by one, illegal codes follow a fixed
    // path that lands back in the decimal range within two steps.
    always_comb begin
        if (legal) begin
            up_val = (cur == TOP_CODE) ? LOW_CODE : digit_t'(cur + 1'b1);
        end else begin
            unique case (cur)
                4'd10:   up_val = 4'd11;
                4'd11:   up_val = 4'd6;
                4'd12:   up_val = 4'd13;
                4'd13:   up_val = 4'd4;
                4'd14:   up_val = 4'd15;
                default: up_val = 4'd2;
            endcase
        end
    end

    // Downward map: every illegal code goes straight to the top digit.
    always_comb begin
        if (!legal || cur == LOW_CODE) begin
            down_val = TOP_CODE;
        end else begin
            down_val = digit_t'(cur - 1'b1);
        end
    end

    assign nxt = (dir_e'(dn) == DIR_DOWN) ? down_val : up_val;

endmodule

// File: rtl/bcd_tc_decode.sv
module bcd_tc_decode
    import bcd_cnt_pkg::*;
(
    input  digit_t cur,
    input  logic   dn,
    output logic   tc
);

    logic at_top;
    logic at_low;

    assign at_top = (cur == TOP_CODE);
    assign at_low = (cur == LOW_CODE);

    always_comb begin
        unique case (dir_e'(dn))
            DIR_UP:   tc = at_top;
            DIR_DOWN: tc = at_low;
            default:  tc = 1'b0;
        endcase
    end

endmodule

// File: rtl/bcd_ripple_gate.sv
module bcd_ripple_gate #(
    parameter bit GATE_WITH_ENABLE = 1'b1
) (
    input  logic clk,
    input  logic tc,
    input  logic ce_n,
    output logic rc_n
);

    logic fire;

    generate
        if (GATE_WITH_ENABLE) begin : g_gated
            assign fire = tc & ~ce_n;
        end else begin : g_plain
            logic unused_ce;
            assign unused_ce = ce_n;
            assign fire = tc;
        end
    endgenerate

    // Active only during the low half of the clock
    assign rc_n = ~(fire & ~clk);

endmodule

// File: rtl/bcd_updown_counter.sv
module bcd_updown_counter
    import bcd_cnt_pkg::*;
(
    input  logic               clk,
    input  logic               load_n,
    input  logic               ce_n,
    input  logic               dn,
    input  logic [DIGIT_W-1:0] preset,
    output logic [DIGIT_W-1:0] count,
    output logic               tc,
    output logic               rc_n
);

    cnt_state_t state_d;
    cnt_state_t state_q;
    digit_t     step_val;

    bcd_step_map u_step (
        .cur (state_q.value),
        .dn  (dn),
        .nxt (step_val)
    );

    always_comb begin
        state_d = state_q;
        if (!ce_n) begin
            state_d.value = step_val;
        end
    end

    // The level load acts as an asynchronous set/clear of each bit
    always_ff @(posedge clk or negedge load_n) begin
        if (!load_n) begin
            state_q <= '{value: preset};
        end else begin
            state_q <= state_d;
        end
    end

    // Transparent path so the output follows preset for the whole load
    assign count = load_n ? state_q.value : preset;

    bcd_tc_decode u_tc (
        .cur (count),
        .dn  (dn),
        .tc  (tc)
    );

    bcd_ripple_gate #(
        .GATE_WITH_ENABLE (1'b1)
    ) u_rc (
        .clk  (clk),
        .tc   (tc),
        .ce_n (ce_n),
        .rc_n (rc_n)
    );

endmodule

// File: rtl/bcd_updown_counter_chk.sv
module bcd_updown_counter_chk
    import bcd_cnt_pkg::*;
(
    input logic               clk,
    input logic               load_n,
    input logic               ce_n,
    input logic               dn,
    input logic [DIGIT_W-1:0] preset,
    input logic [DIGIT_W-1:0] count,
    input logic               tc,
    input logic               rc_n
);

    assert_load_follows_R1: assert property (@(posedge clk)
        !load_n |-> count == preset);

    assert_hold_R2: assert property (@(posedge clk) disable iff (!load_n)
        ($past(load_n) && $past(ce_n)) |-> count == $past(count));

    assert_up_step_R3: assert property (@(posedge clk) disable iff (!load_n)
        ($past(load_n) && !$past(ce_n) && !$past(dn) && $past(count) < 4'd9)
        |-> count == 4'($past(count) + 4'd1));

    assert_down_wrap_R4: assert property (@(posedge clk) disable iff (!load_n)
        ($past(load_n) && !$past(ce_n) && $past(dn) && $past(count) == 4'd0)
        |-> count == 4'd9);

    assert_tc_legal_R5: assert property (@(posedge clk)
        tc |-> (count == 4'd9 || count == 4'd0));

    assert_rc_idle_R6: assert property (@(negedge clk)
        !tc |-> rc_n);

    assert_rc_low_R6: assert property (@(posedge clk)
        (tc && !ce_n) |-> !rc_n);

    assert_illegal_down_R8: assert property (@(posedge clk) disable iff (!load_n)
        ($past(load_n) && !$past(ce_n) && $past(dn) && $past(count) > 4'd9)
        |-> count == 4'd9);

endmodule

bind bcd_updown_counter bcd_updown_counter_chk u_chk (
    .clk    (clk),
    .load_n (load_n),
    .ce_n   (ce_n),
    .dn     (dn),
    .preset (preset),
    .count  (count),
    .tc     (tc),
    .rc_n   (rc_n)
);

// File: tb/bcd_updown_counter_tb.sv
`timescale 1ns/100ps
module bcd_updown_counter_tb;

    logic       clk = 1'b0;
    logic       load_n = 1'b0;
    logic       ce_n = 1'b1;
    logic       dn = 1'b0;
    logic [3:0] preset = 4'd0;
    logic [3:0] count;
    logic       tc;
    logic       rc_n;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [3:0] cnt;
        logic       tcv;
        string      req;
    } exp_t;

    exp_t sb[$];
    logic [3:0] model = 4'd0;

    always #2.5 clk = ~clk;

    bcd_updown_counter u_dut (
        .clk    (clk),
        .load_n (load_n),
        .ce_n   (ce_n),
        .dn     (dn),
        .preset (preset),
        .count  (count),
        .tc     (tc),
        .rc_n   (rc_n)
    );

    function automatic logic [3:0] ref_next(input logic [3:0] v, input logic d);
        if (d) return (v == 4'd0 || v > 4'd9) ? 4'd9 : v - 4'd1;
        case (v)
            4'd9:  return 4'd0;
            4'd10: return 4'd11;
            4'd11: return 4'd6;
            4'd12: return 4'd13;
            4'd13: return 4'd4;
            4'd14: return 4'd15;
            4'd15: return 4'd2;
            default: return v + 4'd1;
        endcase
    endfunction

    function automatic logic ref_tc(input logic [3:0] v, input logic d);
        return d ? (v == 4'd0) : (v == 4'd9);
    endfunction

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: compares scoreboard items just after each rising edge
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(e.req, count, e.cnt);
            check({e.req, " tc"}, {3'b0, tc}, {3'b0, e.tcv});
            check("R6 high phase", {3'b0, rc_n}, 4'd1);
        end
    end

    // Asynchronous load spanning one rising edge with counting enabled
    task automatic do_load(input logic [3:0] v);
        @(negedge clk);
        #1;
        load_n = 1'b0;
        preset = v ^ 4'd5;
        #0.5;
        check("R1 async", count, v ^ 4'd5);
        preset = v;
        #0.5;
        check("R1 follow", count, v);
        ce_n = 1'b0;
        @(posedge clk);
        #1;
        check("R9 load beats count", count, v);
        @(negedge clk);
        load_n = 1'b1;
        ce_n = 1'b1;
        model = v;
        #0.5;
        check("R1 after release", count, v);
    endtask

    // Driver: sets inputs in the low phase and queues the expected result
    task automatic step(input logic c, input logic d, input string req);
        exp_t e;
        logic t;
        @(negedge clk);
        ce_n = c;
        dn = d;
        #0.5;
        t = ref_tc(model, d);
        check({req, " tc low phase R5"}, {3'b0, tc}, {3'b0, t});
        check("R6 low phase", {3'b0, rc_n}, {3'b0, !(t && !c)});
        if (!c) model = ref_next(model, d);
        e.cnt = model;
        e.tcv = ref_tc(model, d);
        e.req = req;
        sb.push_back(e);
    endtask

    initial begin
        do_load(4'd0);
        check("R1 reset state", count, 4'd0);
        check("R5 reset tc", {3'b0, tc}, 4'd0);
        for (int i = 0; i < 12; i++) step(1'b0, 1'b0, "R3 up");
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, "R2 hold");
        for (int i = 0; i < 12; i++) step(1'b0, 1'b1, "R4 down");
        for (int i = 0; i < 2; i++) step(1'b1, 1'b1, "R2 hold down");
        do_load(4'd9);
        step(1'b1, 1'b0, "R2 hold at top");
        step(1'b0, 1'b0, "R3 wrap");
        do_load(4'd3);
        for (int i = 0; i < 5; i++) step(1'b0, 1'b1, "R4 wrap");
        for (int v = 10; v < 16; v++) begin
            do_load(4'(v));
            step(1'b1, 1'b0, "R5 illegal tc");
            step(1'b0, 1'b0, "R7 illegal up");
            step(1'b0, 1'b0, "R7 illegal up");
            step(1'b0, 1'b0, "R7 legal again");
            do_load(4'(v));
            step(1'b0, 1'b1, "R8 illegal down");
            step(1'b0, 1'b1, "R8 legal again");
        end
        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule